// File: doc/BRIEF.md
# Multi-Source Reset Domain Distributor

This block takes six active-low reset sources and produces one active-low reset for each of seven domains. The sources are regulator power-on, external chip-enable power-on, brownout, watchdog timeout, software system reset and thermal reset. The domains are whole-chip, core system, Wi-Fi, Bluetooth, peripherals, always-on peripherals and the always-on independent watchdog. Each source reaches its own set of domains. Four mask inputs can keep the software system reset away from the Wi-Fi, Bluetooth, peripheral and always-on peripheral domains.

A domain reset goes low at once when any source routed to it is active, with no clock needed. It comes back high only after a chain of `SYNC_STAGES` flops, clocked by that domain's own clock, has filled with ones. Four domain clocks are taken in. Even a source glitch far shorter than a clock period therefore yields a clean reset of at least `SYNC_STAGES` cycles in every domain it reaches. The masks are expected to be static while a software reset is active.

Top module: `rst_domain_fanout`

## Requirements
- R1: When `por_n`, `ext_en_n` or `brown_n` is low, all seven domain reset outputs are low.
- R2: When `wdt_n` is low, `sys_rst_n` and `peri_rst_n` are low, while `chip_rst_n`, `wifi_rst_n`, `bt_rst_n`, `aonp_rst_n` and `aonwdt_rst_n` are not affected.
- R3: When `therm_n` is low, `sys_rst_n` and `aonwdt_rst_n` are low, and no other output is affected.
- R4: When `swrst_n` is low, `sys_rst_n` is low. Each of `wifi_rst_n`, `bt_rst_n`, `peri_rst_n` and `aonp_rst_n` is low unless its mask bit (`mask_wifi`, `mask_bt`, `mask_peri`, `mask_aonp`; 1 protects the domain) is 1. `chip_rst_n` and `aonwdt_rst_n` are never affected.
- R5: While `swrst_n` is high, the mask inputs have no effect on any output.
- R6: Reset assertion is asynchronous: an output goes low as soon as a routed source goes low, with no domain clock edge, and stays low without clock edges after the source is released.
- R7: After all sources routed to a domain are high, its output rises on exactly the `SYNC_STAGES`-th rising edge of that domain's clock, and not earlier.
- R8: A source pulse of any width, even one shorter than a clock period, holds each reached output low until `SYNC_STAGES` domain clock edges have followed the pulse.
- R9: Clock assignment: `chip_rst_n` and `sys_rst_n` release on `clk_core`, `wifi_rst_n` and `bt_rst_n` on `clk_radio`, `peri_rst_n` on `clk_peri`, and `aonp_rst_n` and `aonwdt_rst_n` on `clk_aon`. Edges of one clock release no domain of another clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Clock of the whole-chip and core system domains |
| clk_radio | input | 1 | Clock of the Wi-Fi and Bluetooth domains |
| clk_peri | input | 1 | Clock of the peripheral domain |
| clk_aon | input | 1 | Clock of the always-on peripheral and watchdog domains |
| por_n | input | 1 | Regulator power-on reset, active low |
| ext_en_n | input | 1 | External chip-enable power-on reset, active low |
| brown_n | input | 1 | Brownout reset, active low |
| wdt_n | input | 1 | Watchdog timeout reset, active low |
| swrst_n | input | 1 | Software system reset, active low |
| therm_n | input | 1 | Thermal reset, active low |
| mask_wifi | input | 1 | 1 keeps software reset away from Wi-Fi |
| mask_bt | input | 1 | 1 keeps software reset away from Bluetooth |
| mask_peri | input | 1 | 1 keeps software reset away from peripherals |
| mask_aonp | input | 1 | 1 keeps software reset away from always-on peripherals |
| chip_rst_n | output | 1 | Whole-chip domain reset, active low |
| sys_rst_n | output | 1 | Core system domain reset, active low |
| wifi_rst_n | output | 1 | Wi-Fi domain reset, active low |
| bt_rst_n | output | 1 | Bluetooth domain reset, active low |
| peri_rst_n | output | 1 | Peripheral domain reset, active low |
| aonp_rst_n | output | 1 | Always-on peripheral domain reset, active low |
| aonwdt_rst_n | output | 1 | Always-on independent watchdog reset, active low |

## Verification
The bench builds the block with `SYNC_STAGES` = 3. With that value a release one edge early or one edge late is told apart from the correct one, which a two-flop build would hide. The four clocks run free at unrelated periods while routing and masking are checked. They are then frozen, and single edges are issued on one clock at a time. This shows that reset assertion needs no edge, that a one-nanosecond source glitch is stretched, and that each domain waits for its own clock alone.

// File: rtl/rst_domain_fanout.sv
`timescale 1ns/1ps
module rst_domain_fanout #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_core,
  input  logic clk_radio,
  input  logic clk_peri,
  input  logic clk_aon,
  input  logic por_n,
  input  logic ext_en_n,
  input  logic brown_n,
  input  logic wdt_n,
  input  logic swrst_n,
  input  logic therm_n,
  input  logic mask_wifi,
  input  logic mask_bt,
  input  logic mask_peri,
  input  logic mask_aonp,
  output logic chip_rst_n,
  output logic sys_rst_n,
  output logic wifi_rst_n,
  output logic bt_rst_n,
  output logic peri_rst_n,
  output logic aonp_rst_n,
  output logic aonwdt_rst_n
);

  localparam int NDOM = 7;
  localparam int LAST = SYNC_STAGES - 1;

  logic            pwr_n;
  logic [NDOM-1:0] req_n;
  logic [NDOM-1:0] dclk;
  logic [NDOM-1:0] dout_n;

  assign pwr_n = por_n & ext_en_n & brown_n;

  // domain order: chip, sys, wifi, bt, peri, aonp, aonwdt
  assign req_n[0] = pwr_n;
  assign req_n[1] = pwr_n & wdt_n & therm_n & swrst_n;
  assign req_n[2] = pwr_n & (swrst_n | mask_wifi);
  assign req_n[3] = pwr_n & (swrst_n | mask_bt);
  assign req_n[4] = pwr_n & wdt_n & (swrst_n | mask_peri);
  assign req_n[5] = pwr_n & (swrst_n | mask_aonp);
  assign req_n[6] = pwr_n & therm_n;

  assign dclk = {clk_aon, clk_aon, clk_peri, clk_radio, clk_radio, clk_core, clk_core};

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    logic [LAST:0] chain;
    always_ff @(posedge dclk[d] or negedge req_n[d]) begin
      if (!req_n[d]) chain <= '0;
      else           chain <= {chain[LAST-1:0], 1'b1};
    end
    assign dout_n[d] = chain[LAST];
  end

  assign chip_rst_n   = dout_n[0];
  assign sys_rst_n    = dout_n[1];
  assign wifi_rst_n   = dout_n[2];
  assign bt_rst_n     = dout_n[3];
  assign peri_rst_n   = dout_n[4];
  assign aonp_rst_n   = dout_n[5];
  assign aonwdt_rst_n = dout_n[6];

  AST_PWR_CHIP: assert property (@(posedge clk_core) disable iff (!por_n)
    (!ext_en_n || !brown_n) |-> !chip_rst_n); // R1
  AST_PWR_AON: assert property (@(posedge clk_aon) disable iff (!por_n)
    (!ext_en_n || !brown_n) |-> (!aonp_rst_n && !aonwdt_rst_n)); // R1
  AST_WDG_SYS: assert property (@(posedge clk_core) disable iff (!por_n)
    !wdt_n |-> !sys_rst_n); // R2
  AST_WDG_PERI: assert property (@(posedge clk_peri) disable iff (!por_n)
    !wdt_n |-> !peri_rst_n); // R2
  AST_THM_AONWDT: assert property (@(posedge clk_aon) disable iff (!por_n)
    !therm_n |-> !aonwdt_rst_n); // R3
  AST_SW_WIFI: assert property (@(posedge clk_radio) disable iff (!por_n)
    (!swrst_n && !mask_wifi) |-> !wifi_rst_n); // R4
  AST_REL_SYS: assert property (@(posedge clk_core) disable iff (!por_n)
    $rose(sys_rst_n) |-> $past(req_n[1])); // R7
  AST_HOLD_SYS: assert property (@(posedge clk_core) disable iff (!por_n)
    $fell(sys_rst_n) |=> !sys_rst_n); // R8

endmodule

// File: tb/rst_domain_fanout_tb_top.sv
`timescale 1ns/1ps
module rst_domain_fanout_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES = 3;
  localparam int CORE = 0, RADIO = 1, PERI = 2, AON = 3;

  logic fr_core = 0, fr_radio = 0, fr_peri = 0, fr_aon = 0;
  logic [3:0] man = '0;
  logic run = 1'b1;
  logic clk_core, clk_radio, clk_peri, clk_aon;
  logic por_n, ext_en_n, brown_n, wdt_n, swrst_n, therm_n;
  logic mask_wifi, mask_bt, mask_peri, mask_aonp;
  logic chip_rst_n, sys_rst_n, wifi_rst_n, bt_rst_n, peri_rst_n, aonp_rst_n, aonwdt_rst_n;

  always #(CLK_PERIOD/2) fr_core  = ~fr_core;
  always #7              fr_radio = ~fr_radio;
  always #11             fr_peri  = ~fr_peri;
  always #17             fr_aon   = ~fr_aon;

  assign clk_core  = run ? fr_core  : man[CORE];
  assign clk_radio = run ? fr_radio : man[RADIO];
  assign clk_peri  = run ? fr_peri  : man[PERI];
  assign clk_aon   = run ? fr_aon   : man[AON];

  rst_domain_fanout #(.SYNC_STAGES(STAGES)) dut_i (
    .clk_core(clk_core), .clk_radio(clk_radio), .clk_peri(clk_peri), .clk_aon(clk_aon),
    .por_n(por_n), .ext_en_n(ext_en_n), .brown_n(brown_n), .wdt_n(wdt_n),
    .swrst_n(swrst_n), .therm_n(therm_n),
    .mask_wifi(mask_wifi), .mask_bt(mask_bt), .mask_peri(mask_peri), .mask_aonp(mask_aonp),
    .chip_rst_n(chip_rst_n), .sys_rst_n(sys_rst_n), .wifi_rst_n(wifi_rst_n), .bt_rst_n(bt_rst_n),
    .peri_rst_n(peri_rst_n), .aonp_rst_n(aonp_rst_n), .aonwdt_rst_n(aonwdt_rst_n));

  // bit order {aonwdt, aonp, peri, bt, wifi, sys, chip}; 0 = domain in reset
  logic [6:0] act;
  assign act = {aonwdt_rst_n, aonp_rst_n, peri_rst_n, bt_rst_n, wifi_rst_n, sys_rst_n, chip_rst_n};

  typedef struct { logic [6:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  initial begin
    item_t it;
    forever begin
      wait (q.size() != 0);
      it = q.pop_front();
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%b expected=%b", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_now(input logic [6:0] e, input string tag);
    #1;
    q.push_back('{e, tag});
    #1;
  endtask

  task automatic edges(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      man[which] = 1'b1; #5;
      man[which] = 1'b0; #5;
    end
  endtask

  task automatic settle();
    #400;
  endtask

  initial begin
    por_n = 0; ext_en_n = 1; brown_n = 1; wdt_n = 1; swrst_n = 1; therm_n = 1;
    mask_wifi = 0; mask_bt = 0; mask_peri = 0; mask_aonp = 0;
    #50;
    expect_now(7'b0000000, "R1 power-on reset state");
    por_n = 1; settle();
    expect_now(7'b1111111, "R7 release after power-on");

    ext_en_n = 0; #30;
    expect_now(7'b0000000, "R1 external power-on");
    ext_en_n = 1; settle();
    expect_now(7'b1111111, "R7 release after external");
    brown_n = 0; #30;
    expect_now(7'b0000000, "R1 brownout");
    brown_n = 1; settle();
    expect_now(7'b1111111, "R7 release after brownout");

    wdt_n = 0; #60;
    expect_now(7'b1101101, "R2 watchdog routing");
    wdt_n = 1; settle();
    expect_now(7'b1111111, "R2 release after watchdog");
    therm_n = 0; #60;
    expect_now(7'b0111101, "R3 thermal routing");
    therm_n = 1; settle();
    expect_now(7'b1111111, "R3 release after thermal");

    swrst_n = 0; #60;
    expect_now(7'b1000001, "R4 software reset unmasked");
    swrst_n = 1; settle();
    mask_wifi = 1; mask_peri = 1; #20;
    swrst_n = 0; #60;
    expect_now(7'b1010101, "R4 software reset wifi+peri masked");
    swrst_n = 1; settle();
    mask_bt = 1; mask_aonp = 1; #20;
    swrst_n = 0; #60;
    expect_now(7'b1111101, "R4 software reset all masked");
    swrst_n = 1; settle();
    expect_now(7'b1111111, "R5 masks alone have no effect");
    mask_wifi = 0; mask_bt = 0; mask_peri = 0; mask_aonp = 0; settle();
    expect_now(7'b1111111, "R5 mask removal has no effect");

    run = 0; #40;
    wdt_n = 0;
    expect_now(7'b1101101, "R6 assertion with clocks stopped");
    wdt_n = 1;
    expect_now(7'b1101101, "R6 held without edges");
    edges(PERI, STAGES - 1);
    expect_now(7'b1101101, "R7 peri before last edge");
    edges(PERI, 1);
    expect_now(7'b1111101, "R9 peri released, sys waits on core");
    edges(CORE, STAGES - 1);
    expect_now(7'b1111101, "R7 sys before last edge");
    edges(CORE, 1);
    expect_now(7'b1111111, "R7 sys released");

    therm_n = 0; #1; therm_n = 1;
    expect_now(7'b0111101, "R8 short thermal pulse stretched");
    edges(CORE, STAGES - 1);
    expect_now(7'b0111101, "R8 sys still low");
    edges(CORE, 1);
    expect_now(7'b0111111, "R9 sys up, aonwdt waits on aon");
    edges(AON, STAGES - 1);
    expect_now(7'b0111111, "R8 aonwdt still low");
    edges(AON, 1);
    expect_now(7'b1111111, "R8 aonwdt released");

    por_n = 0; #1; por_n = 1;
    expect_now(7'b0000000, "R8 short power-on pulse");
    edges(CORE, STAGES);
    expect_now(7'b0000011, "R9 core domains only");
    edges(RADIO, STAGES);
    expect_now(7'b0001111, "R9 radio domains");
    edges(PERI, STAGES);
    expect_now(7'b0011111, "R9 peri domain");
    edges(AON, STAGES);
    expect_now(7'b1111111, "R9 aon domains");

    run = 1;
    wait (q.size() == 0);
    #2;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule